// File: doc/BRIEF.md
# Multi-format stereo serial audio port

This block is a slave-mode stereo serial audio port. An external master supplies the bit clock and the frame clock. The receive half turns the serial data input into a pair of parallel left and right samples. The transmit half turns a parallel pair back into serial data on the output. Three framings are handled by the same slot engine: I2S, left-justified, and right-justified at either 16 or 24 bits. A 3-bit format code selects the framing. A 2-bit ratio code gives the number of bit clocks per frame.

The serial clock, frame clock and data input are first synchronised into the system clock domain. The block then finds the serial clock edges itself. Bits are captured on rising serial clock edges and driven after falling ones. A slot counter restarts at every frame clock transition. For the current framing, each slot number is mapped to a position in the sample word, or to no position at all.

Received pairs are left-aligned in 24-bit words, and a strobe marks each new pair. A transmit pair is written with a load strobe and is used from the next left half-frame onward.

Top module: `sap_port`

## Requirements
- R1: Format code 000 selects left-justified framing. The left channel is the frame-clock-high half, and word bit 23 (MSB) occupies slot 0 of each half-frame, the first bit clock after the transition.
- R2: Format code 001 selects I2S. The left channel is the frame-clock-low half, and the MSB occupies slot 1 of each half-frame. Slot 0 is ignored on receive and driven 0 on transmit.
- R3: Format code 010 selects right-justified 16-bit and code 101 selects right-justified 24-bit. The left channel is frame-clock-high, and the LSB sits in the last slot of each half-frame. If the half-frame is shorter than the word, the upper bits of the word are lost.
- R4: The reserved codes 011, 100, 110 and 111 behave exactly as I2S (code 001).
- R5: Ratio code 00, 01, 10 and 11 give 32, 48, 64 and 128 bit clocks per frame, so a half-frame has 16, 24, 32 or 64 slots. A word bit that has no slot inside the half-frame is not carried: an I2S word at ratio 48 keeps only 23 bits.
- R6: Each received pair is presented on rx_left/rx_right as 24-bit words. The bits that were carried are left-aligned, and every other bit is 0. Slots outside the word are ignored. rx_valid pulses for one clock at each entry into a left half-frame, except the first one after reset, and it then carries the pair of the frame just completed.
- R7: sdata_out changes only after a falling bit-clock edge. It holds steady for the whole following bit period, and slots outside the word are driven 0.
- R8: A tx_load pulse stores tx_left/tx_right. The stored pair is sent starting at the next left half-frame. Without a new load, the last pair is sent again in every frame.
- R9: While rst_n is low at a clock edge, sdata_out, rx_valid, rx_left and rx_right are 0 and the stored transmit pair is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_code | input | 3 | Framing selector (see R1 to R4) |
| ratio_code | input | 2 | Bit clocks per frame selector (see R5) |
| sclk_in | input | 1 | External serial bit clock |
| lrck_in | input | 1 | External frame (channel select) clock |
| sdata_in | input | 1 | Serial data from the external transmitter |
| sdata_out | output | 1 | Serial data to the external receiver |
| tx_load | input | 1 | Strobe that stores the transmit pair |
| tx_left | input | 24 | Left sample to transmit, MSB first |
| tx_right | input | 24 | Right sample to transmit, MSB first |
| rx_left | output | 24 | Last received left sample, left-aligned |
| rx_right | output | 24 | Last received right sample, left-aligned |
| rx_valid | output | 1 | One-clock strobe for a new received pair |

## Verification
Some properties are checked on every clock. rx_valid is always a single-clock pulse, and it only follows a rising bit-clock edge that opens a left half-frame. The serial output never moves except right after a detected falling edge. The active transmit pair is only swapped at the falling edge that opens a left half-frame.

Other behaviours can only be shown by the bench's scenarios. These are the slot-to-bit mapping of each framing, the fallback of the reserved codes to I2S, and the truncation at short frame lengths. The same holds for left-alignment with zero fill, the ignoring of junk bits outside the word, the repetition of an unreloaded pair, and the clearing by reset.

// File: rtl/sap_pkg.sv
// Shared types and slot mapping for the serial audio port.
// Assumes a 24-bit sample word; shorter words are left-aligned in it.
package sap_pkg;

    localparam int SAMPLE_W = 24;
    localparam int BITPOS_W = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_RJ16 = 2'd2,
        FMT_RJ24 = 2'd3
    } fmt_e;

    // Result of mapping one slot: whether it carries a word bit, and which.
    typedef struct packed {
        logic                hit;
        logic [BITPOS_W-1:0] pos;
    } slot_map_t;

    // Coded format field to framing; every unlisted code falls back to I2S.
    function automatic fmt_e decode_fmt(input logic [2:0] code);
        case (code)
            3'b000:  return FMT_LJ;
            3'b010:  return FMT_RJ16;
            3'b101:  return FMT_RJ24;
            default: return FMT_I2S;
        endcase
    endfunction

    // Slots per half-frame for the ratio code (32, 48, 64, 128 per frame).
    function automatic int half_slots(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 24;
            2'b10:   return 32;
            default: return 64;
        endcase
    endfunction

    // Map a slot number inside a half-frame to a word bit position.
    function automatic slot_map_t map_slot(input fmt_e f, input int half, input int slot);
        int        off;
        int        wlen;
        int        k;
        slot_map_t m;
        wlen = (f == FMT_RJ16) ? 16 : SAMPLE_W;
        case (f)
            FMT_LJ:  off = 0;
            FMT_I2S: off = 1;
            default: off = half - wlen;
        endcase
        k     = slot - off;
        m.hit = (k >= 0) && (k < wlen);
        m.pos = m.hit ? BITPOS_W'(SAMPLE_W - 1 - k) : '0;
        return m;
    endfunction

    // Frame-clock level that marks the left channel for a framing.
    function automatic logic left_level(input fmt_e f, input logic lr);
        return (f == FMT_I2S) ? ~lr : lr;
    endfunction

endpackage

// File: rtl/sap_edge_sync.sv
// Synchronises the bit clock, frame clock and data input into clk and
// flags bit-clock edges. Assumes each bit-clock phase lasts several clk
// periods. All three lanes share the same depth, so the frame clock and
// data stay aligned with the detected edges.
module sap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic lrck_in,
    input  logic sdin_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic lrck_s,
    output logic sdin_s
);

    localparam int LANES = 3;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic             sclk_d;

    assign raw = {sdin_in, lrck_in, sclk_in};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [STAGES-1:0] chain;
        // Shift the raw input through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], raw[i]};
        end
        assign synced[i] = chain[STAGES-1];
    end

    // Keep the previous synchronised bit clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= synced[0];
    end

    assign sclk_rise = synced[0] & ~sclk_d;
    assign sclk_fall = ~synced[0] & sclk_d;
    assign lrck_s    = synced[1];
    assign sdin_s    = synced[2];

endmodule

// File: rtl/sap_slot_ctrl.sv
// Tracks the slot number inside the current half-frame and maps it to a
// word bit for the selected framing. The value it presents is the slot of
// the bit period now starting (on a fall) or now being sampled (on a
// rise); both use the counter updated on the previous rise.
module sap_slot_ctrl
    import sap_pkg::*;
#(
    parameter int SLOT_W = 7
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk_rise,
    input  logic      lrck_s,
    input  logic [2:0] fmt_code,
    input  logic [1:0] ratio_code,
    output logic      half_start,
    output logic      is_left,
    output slot_map_t cur_map
);

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_c;
    logic              lrck_r;
    fmt_e              fmt;
    int                half;

    // Decode the framing and compute the slot and its word bit.
    always_comb begin
        fmt        = decode_fmt(fmt_code);
        half       = half_slots(ratio_code);
        half_start = (lrck_s != lrck_r);
        if (half_start)       slot_c = '0;
        else if (&slot_q)     slot_c = slot_q;
        else                  slot_c = slot_q + 1'b1;
        is_left    = left_level(fmt, lrck_s);
        cur_map    = map_slot(fmt, half, int'(slot_c));
    end

    // Commit slot number and frame-clock level at each rising bit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            lrck_r <= 1'b0;
        end else if (sclk_rise) begin
            slot_q <= slot_c;
            lrck_r <= lrck_s;
        end
    end

endmodule

// File: rtl/sap_rx.sv
// Receive half: collects sampled bits into per-channel words and presents
// the completed pair when a new left half-frame begins. Assumes slot
// mapping and channel come from the slot controller for the same rise.
module sap_rx
    import sap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_rise,
    input  logic                half_start,
    input  logic                is_left,
    input  slot_map_t           cur_map,
    input  logic                sdin_s,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    logic [SAMPLE_W-1:0] acc_l, acc_r;
    logic [SAMPLE_W-1:0] acc_l_n, acc_r_n;
    logic                seen_left;

    // Next accumulator values: clear on a new half, then drop in the bit.
    always_comb begin
        acc_l_n = acc_l;
        acc_r_n = acc_r;
        if (half_start) begin
            if (is_left) acc_l_n = '0;
            else         acc_r_n = '0;
        end
        if (cur_map.hit) begin
            if (is_left) acc_l_n[cur_map.pos] = sdin_s;
            else         acc_r_n[cur_map.pos] = sdin_s;
        end
    end

    // Update accumulators on rises and publish the pair at left entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_l     <= '0;
            acc_r     <= '0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_valid  <= 1'b0;
            seen_left <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sclk_rise) begin
                acc_l <= acc_l_n;
                acc_r <= acc_r_n;
                if (half_start && is_left) begin
                    if (seen_left) begin
                        rx_left  <= acc_l;
                        rx_right <= acc_r;
                        rx_valid <= 1'b1;
                    end
                    seen_left <= 1'b1;
                end
            end
        end
    end

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_valid_left_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sclk_rise && half_start && is_left));

endmodule

// File: rtl/sap_tx.sv
// Transmit half: holds a pending and an active sample pair, swaps them at
// the falling edge that opens a left half-frame, and drives one word bit
// (or zero) per slot. Assumes the frame clock changes with a falling edge.
module sap_tx
    import sap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_fall,
    input  logic                half_start,
    input  logic                is_left,
    input  slot_map_t           cur_map,
    input  logic                tx_load,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                sdata_out
);

    logic [SAMPLE_W-1:0] pend_l, pend_r;
    logic [SAMPLE_W-1:0] act_l, act_r;
    logic [SAMPLE_W-1:0] word;
    logic                swap;

    // Pick the word for the slot now opening.
    always_comb begin
        swap = half_start && is_left;
        if (swap)         word = pend_l;
        else if (is_left) word = act_l;
        else              word = act_r;
    end

    // Store loaded pairs, swap them in at left entry, drive the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l    <= '0;
            pend_r    <= '0;
            act_l     <= '0;
            act_r     <= '0;
            sdata_out <= 1'b0;
        end else begin
            if (tx_load) begin
                pend_l <= tx_left;
                pend_r <= tx_right;
            end
            if (sclk_fall) begin
                if (swap) begin
                    act_l <= pend_l;
                    act_r <= pend_r;
                end
                sdata_out <= cur_map.hit ? word[cur_map.pos] : 1'b0;
            end
        end
    end

    p_out_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_out != $past(sdata_out)) |-> $past(sclk_fall));

    p_swap_at_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_l != $past(act_l)) |-> $past(sclk_fall && half_start && is_left));

endmodule

// File: rtl/sap_port.sv
// Top of the slave serial audio port: synchroniser and edge detector,
// shared slot controller, receive and transmit halves. Assumes bit and
// frame clocks are driven by an external master much slower than clk.
module sap_port
    import sap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SLOT_W      = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_code,
    input  logic [1:0]          ratio_code,
    input  logic                sclk_in,
    input  logic                lrck_in,
    input  logic                sdata_in,
    output logic                sdata_out,
    input  logic                tx_load,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    logic      sclk_rise, sclk_fall, lrck_s, sdin_s;
    logic      half_start, is_left;
    slot_map_t cur_map;

    sap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .lrck_in   (lrck_in),
        .sdin_in   (sdata_in),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .lrck_s    (lrck_s),
        .sdin_s    (sdin_s)
    );

    sap_slot_ctrl #(.SLOT_W(SLOT_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise),
        .lrck_s     (lrck_s),
        .fmt_code   (fmt_code),
        .ratio_code (ratio_code),
        .half_start (half_start),
        .is_left    (is_left),
        .cur_map    (cur_map)
    );

    sap_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise),
        .half_start (half_start),
        .is_left    (is_left),
        .cur_map    (cur_map),
        .sdin_s     (sdin_s),
        .rx_left    (rx_left),
        .rx_right   (rx_right),
        .rx_valid   (rx_valid)
    );

    sap_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_fall  (sclk_fall),
        .half_start (half_start),
        .is_left    (is_left),
        .cur_map    (cur_map),
        .tx_load    (tx_load),
        .tx_left    (tx_left),
        .tx_right   (tx_right),
        .sdata_out  (sdata_out)
    );

endmodule

// File: tb/tb_sap_port.sv
module tb_sap_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_code = 3'b001;
    logic [1:0]  ratio_code = 2'b10;
    logic        sclk_in = 1'b0;
    logic        lrck_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic        sdata_out;
    logic        tx_load = 1'b0;
    logic [23:0] tx_left = '0;
    logic [23:0] tx_right = '0;
    logic [23:0] rx_left, rx_right;
    logic        rx_valid;

    sap_port dut (
        .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .ratio_code(ratio_code),
        .sclk_in(sclk_in), .lrck_in(lrck_in), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .tx_load(tx_load), .tx_left(tx_left),
        .tx_right(tx_right), .rx_left(rx_left), .rx_right(rx_right),
        .rx_valid(rx_valid)
    );

    always #5 clk = ~clk;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cap_n = 0;
    logic [23:0] cap_l = '0, cap_r = '0;

    // Record every received pair.
    always @(posedge clk) begin
        if (rx_valid) begin
            cap_l <= rx_left;
            cap_r <= rx_right;
            cap_n <= cap_n + 1;
        end
    end

    // vector: mode(3) ratio(2) expected framing(2: 0 LJ,1 I2S,2 RJ16,3 RJ24) left(24) right(24)
    localparam int NV = 14;
    localparam logic [54:0] VECS [0:NV-1] = '{
        {3'b000, 2'b10, 2'd0, 24'hA1B2C3, 24'h5E6F70},
        {3'b001, 2'b10, 2'd1, 24'h8F0F0F, 24'h13579B},
        {3'b010, 2'b10, 2'd2, 24'hC35A00, 24'h7E8100},
        {3'b101, 2'b10, 2'd3, 24'h92468A, 24'h0F1E2D},
        {3'b001, 2'b00, 2'd1, 24'hF00DAB, 24'h3CC3A5},
        {3'b000, 2'b01, 2'd0, 24'h123457, 24'hFEDCBB},
        {3'b101, 2'b11, 2'd3, 24'hB7E151, 24'h628AED},
        {3'b010, 2'b01, 2'd2, 24'hDEAD00, 24'h4B1D00},
        {3'b011, 2'b10, 2'd1, 24'h5A5A5B, 24'hC0FFEE},
        {3'b110, 2'b01, 2'd1, 24'hABCDEF, 24'h987655},
        {3'b100, 2'b00, 2'd1, 24'h8000FF, 24'h7FFF01},
        {3'b111, 2'b11, 2'd1, 24'h31415A, 24'h27182B},
        {3'b101, 2'b00, 2'd3, 24'hE4D3C2, 24'h1A2B3C},
        {3'b001, 2'b01, 2'd1, 24'h6B6B6B, 24'h9C9C9D}
    };

    int          g_half, g_off, g_wlen;
    logic        g_left_lvl;
    logic [23:0] exp_l, exp_r;
    int          tx_err;

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Configure framing and compute the bench's own slot layout.
    task automatic prep(input logic [2:0] mode, input logic [1:0] ratio, input logic [1:0] eff);
        @(negedge clk);
        fmt_code   = mode;
        ratio_code = ratio;
        case (ratio)
            2'b00:   g_half = 16;
            2'b01:   g_half = 24;
            2'b10:   g_half = 32;
            default: g_half = 64;
        endcase
        g_wlen     = (eff == 2'd2) ? 16 : 24;
        g_off      = (eff == 2'd0) ? 0 : (eff == 2'd1) ? 1 : g_half - g_wlen;
        g_left_lvl = (eff == 2'd1) ? 1'b0 : 1'b1;
    endtask

    // One bit period: drive on the falling edge, sample output twice.
    task automatic slot(input logic lv, input logic d, input logic expbit, input bit chk_tx);
        logic so1, so2;
        @(negedge clk);
        sclk_in  = 1'b0;
        lrck_in  = lv;
        sdata_in = d;
        repeat (8) @(negedge clk);
        so1 = sdata_out;
        sclk_in = 1'b1;
        repeat (7) @(negedge clk);
        so2 = sdata_out;
        if (chk_tx && (so1 !== expbit || so2 !== so1)) tx_err++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) slot(~g_left_lvl, 1'b0, 1'b0, 0);
    endtask

    task automatic load(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        tx_left  = l;
        tx_right = r;
        tx_load  = 1'b1;
        @(negedge clk);
        tx_load  = 1'b0;
    endtask

    // One full frame: send L/R serially, expect tL/tR on the output.
    task automatic body(input logic [23:0] l, input logic [23:0] r,
                        input logic [23:0] tl, input logic [23:0] tr);
        exp_l  = '0;
        exp_r  = '0;
        tx_err = 0;
        for (int ch = 0; ch < 2; ch++) begin
            for (int s = 0; s < g_half; s++) begin
                int   k;
                logic d, e;
                k = s - g_off;
                if (k >= 0 && k < g_wlen) begin
                    d = (ch == 0) ? l[23-k] : r[23-k];
                    e = (ch == 0) ? tl[23-k] : tr[23-k];
                    if (ch == 0) exp_l[23-k] = d;
                    else         exp_r[23-k] = d;
                end else begin
                    d = 1'b1;
                    e = 1'b0;
                end
                slot((ch == 0) ? g_left_lvl : ~g_left_lvl, d, e, 1);
            end
        end
    endtask

    task automatic trail();
        slot(g_left_lvl, 1'b0, 1'b0, 0);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] tl, tr;
        int          n0;
        string       tag;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(sdata_out == 1'b0 && rx_valid == 1'b0 && rx_left == '0 && rx_right == '0,
              "R9 reset outputs", {rx_left, rx_right}, 48'd0);

        for (int v = 0; v < NV; v++) begin
            logic [2:0]  m;
            logic [1:0]  ra, ef;
            logic [23:0] vl, vr;
            {m, ra, ef, vl, vr} = VECS[v];
            if (m == 3'b011 || m == 3'b100 || m == 3'b110 || m == 3'b111) tag = "R4";
            else if (ef == 2'd0) tag = "R1";
            else if (ef == 2'd1) tag = "R2";
            else tag = "R3";
            tl = vl ^ 24'h5A3C96;
            tr = vr ^ 24'hA5C369;
            prep(m, ra, ef);
            idle(2);
            load(tl, tr);
            body(vl, vr, tl, tr);
            trail();
            check(cap_l == exp_l && cap_r == exp_r, {tag, " R5 R6 receive"},
                  {cap_l, cap_r}, {exp_l, exp_r});
            check(tx_err == 0, {tag, " R5 R7 transmit"}, 48'(tx_err), 48'd0);
        end

        // R8: no new load, last pair (from the final vector) repeats
        prep(3'b000, 2'b10, 2'd0);
        idle(2);
        body(24'h000001, 24'h800000, tl, tr);
        trail();
        check(tx_err == 0, "R8 repeat without load", 48'(tx_err), 48'd0);

        // R6: one pulse per left entry over back-to-back frames
        load(24'h0F0F0F, 24'hF0F0F0);
        idle(2);
        n0 = cap_n;
        body(24'h111111, 24'h222222, 24'h0F0F0F, 24'hF0F0F0);
        body(24'hABCDEF, 24'h654321, 24'h0F0F0F, 24'hF0F0F0);
        trail();
        check(cap_n - n0 == 3, "R6 pulse count", 48'(cap_n - n0), 48'd3);
        check(cap_l == 24'hABCDEF && cap_r == 24'h654321, "R6 back-to-back pair",
              {cap_l, cap_r}, {24'hABCDEF, 24'h654321});

        // R9: reset mid-run clears outputs and the stored pair
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(sdata_out == 1'b0 && rx_valid == 1'b0 && rx_left == '0 && rx_right == '0,
              "R9 mid-run reset", {rx_left, rx_right}, 48'd0);
        rst_n = 1'b1;
        idle(2);
        body(24'h777777, 24'h999999, 24'h000000, 24'h000000);
        trail();
        check(tx_err == 0, "R9 R8 cleared transmit pair", 48'(tx_err), 48'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule